// File: doc/BRIEF.md
# SATA Port Task-File Shadow Registers

This block holds, for one port of a SATA host controller, the copies of device state that software reads: the device's status and error bytes, the device signature, a mirror of the link status word and an accumulated set of completed command slots. Software cannot write these copies. They change only when the receive path hands over a decoded device-to-host frame. A register frame and a PIO setup frame replace the status and error bytes. A set-device-bits frame replaces the error byte and merges the status byte, but keeps the busy and data-request bits that were already there. It also adds completion bits to the accumulator.

Each frame also produces a one-cycle interrupt request. A set-device-bits frame always raises its own request. A register or PIO setup frame raises a task-file error request when it reports an error. Software clears completion bits by writing ones to them. Reads are combinational from the stored state, so a read never triggers a refresh of the shadows.

Top module: `sata_port_shadow_regs`

## Requirements
- R1: When synchronous reset is released, register offset 0 reads 0x0000007F, offset 1 reads 0xFFFFFFFF, offset 3 reads 0, and both interrupt outputs are low.
- R2: The register map uses word offsets: 0 is task-file data, with the error byte in bits 15:8, the status byte in bits 7:0 and zeros above; 1 is the signature; 2 is the `link_status` input; 3 is the completion accumulator. Any other offset reads 0. Read data reflects the state after the last clock edge, so a read in the same cycle as a frame returns the old value.
- R3: Writes to offsets 0, 1 and 2 change no register.
- R4: Frame kinds are encoded as 0 for register, 1 for PIO setup, 2 for set-device-bits and 3 for reserved. A register or PIO setup frame loads offset 0 with {error, status}, and the new value is readable after the next clock edge.
- R5: A set-device-bits frame loads the error byte in full. Status bits 0x77 come from the frame and status bits 0x88 (busy, data request) keep their previous values.
- R6: A register or PIO setup frame whose status bit 0 is set raises `irq_tferr` for exactly the one cycle after the frame. Other frames never raise it.
- R7: Every set-device-bits frame raises `irq_sdb` for exactly the one cycle after the frame. No other frame raises it.
- R8: A set-device-bits frame ORs `frm_done` into the completion accumulator. A reserved-kind frame changes no register and raises no interrupt.
- R9: Writing to offset 3 clears the accumulator bits that are 1 in the write data. If a clear and a set-device-bits frame arrive in the same cycle, the newly set bits survive.
- R10: Only the first register frame after reset loads `frm_sig` into the signature. PIO setup frames, set-device-bits frames and later register frames leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high port reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| link_status | input | 32 | Link status word shown at offset 2 |
| frm_valid | input | 1 | A decoded received frame is present this cycle |
| frm_kind | input | 2 | Frame kind: 0 register, 1 PIO setup, 2 set-device-bits, 3 reserved |
| frm_status | input | 8 | Status byte carried by the frame |
| frm_error | input | 8 | Error byte carried by the frame |
| frm_done | input | SLOT_N | Completion bits of a set-device-bits frame |
| frm_sig | input | 32 | Signature carried by a register frame |
| irq_tferr | output | 1 | Task-file error interrupt pulse |
| irq_sdb | output | 1 | Set-device-bits interrupt pulse |

## Verification
The hardest cases to reach are the busy and data-request bits surviving a set-device-bits merge. The ports can only set those bits with an earlier register or PIO setup frame. So the stimulus first primes the task-file with each of the four busy/data-request combinations through a PIO frame, then sweeps all 256 status values of a set-device-bits frame on top of it. The signature's first-frame-only rule is reached by resetting and leading with a PIO frame before the first register frame. A completion clear is written in the same cycle as a set-device-bits frame to hit the set-wins case.

// File: rtl/sata_shadow_pkg.sv
package sata_shadow_pkg;

    localparam int DATA_W = 32;

    typedef enum logic [1:0] {
        FRM_REG  = 2'd0,
        FRM_PIO  = 2'd1,
        FRM_SDB  = 2'd2,
        FRM_RSVD = 2'd3
    } frm_kind_e;

    localparam logic [15:0]       TFD_AT_RESET = 16'h007F;
    localparam logic [DATA_W-1:0] SIG_AT_RESET = '1;
    localparam logic [7:0]        STS_KEEP     = 8'h88;

    localparam int OFS_TFD  = 0;
    localparam int OFS_SIG  = 1;
    localparam int OFS_LINK = 2;
    localparam int OFS_CMPL = 3;

    typedef struct packed {
        logic            vld;
        frm_kind_e       kind;
        logic [7:0]      status;
        logic [7:0]      error;
        logic [DATA_W-1:0] sig;
    } rx_frame_t;

    function automatic logic [7:0] sdb_merge(input logic [7:0] prev, input logic [7:0] incoming);
        return (prev & STS_KEEP) | (incoming & ~STS_KEEP);
    endfunction

endpackage

// File: rtl/sata_tf_shadow.sv
module sata_tf_shadow
    import sata_shadow_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  rx_frame_t         frm,
    output logic [15:0]       tfd_q,
    output logic [DATA_W-1:0] sig_q,
    output logic              sig_seen_q,
    output logic              irq_tferr,
    output logic              irq_sdb
);

    always_ff @(posedge clk) begin
        if (rst) begin
            tfd_q      <= TFD_AT_RESET;
            sig_q      <= SIG_AT_RESET;
            sig_seen_q <= 1'b0;
            irq_tferr  <= 1'b0;
            irq_sdb    <= 1'b0;
        end else begin
            irq_tferr <= 1'b0;
            irq_sdb   <= 1'b0;
            if (frm.vld) begin
                unique case (frm.kind)
                    FRM_REG: begin
                        tfd_q     <= {frm.error, frm.status};
                        irq_tferr <= frm.status[0];
                        if (!sig_seen_q) begin
                            sig_q      <= frm.sig;
                            sig_seen_q <= 1'b1;
                        end
                    end
                    FRM_PIO: begin
                        tfd_q     <= {frm.error, frm.status};
                        irq_tferr <= frm.status[0];
                    end
                    FRM_SDB: begin
                        tfd_q   <= {frm.error, sdb_merge(tfd_q[7:0], frm.status)};
                        irq_sdb <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/sata_cmpl_accum.sv
module sata_cmpl_accum #(
    parameter int SLOT_N = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              set_vld,
    input  logic [SLOT_N-1:0] set_bits,
    input  logic              clr_vld,
    input  logic [SLOT_N-1:0] clr_bits,
    output logic [SLOT_N-1:0] acc_q
);

    logic [SLOT_N-1:0] clr_mask;
    logic [SLOT_N-1:0] set_mask;

    always_comb begin
        clr_mask = clr_vld ? clr_bits : '0;
        set_mask = set_vld ? set_bits : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) acc_q <= '0;
        else     acc_q <= (acc_q & ~clr_mask) | set_mask;
    end

endmodule

// File: rtl/sata_reg_rdmux.sv
module sata_reg_rdmux
    import sata_shadow_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       tfd,
    input  logic [DATA_W-1:0] sig,
    input  logic [DATA_W-1:0] link,
    input  logic [DATA_W-1:0] cmpl,
    output logic [DATA_W-1:0] rdata
);

    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(OFS_TFD))       rdata = {{(DATA_W-16){1'b0}}, tfd};
        else if (addr == ADDR_W'(OFS_SIG))  rdata = sig;
        else if (addr == ADDR_W'(OFS_LINK)) rdata = link;
        else if (addr == ADDR_W'(OFS_CMPL)) rdata = cmpl;
    end

endmodule

// File: rtl/sata_port_shadow_regs.sv
module sata_port_shadow_regs
    import sata_shadow_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int SLOT_N = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [31:0]       link_status,
    input  logic              frm_valid,
    input  logic [1:0]        frm_kind,
    input  logic [7:0]        frm_status,
    input  logic [7:0]        frm_error,
    input  logic [SLOT_N-1:0] frm_done,
    input  logic [31:0]       frm_sig,
    output logic              irq_tferr,
    output logic              irq_sdb
);

    localparam logic [ADDR_W-1:0] CMPL_ADDR = ADDR_W'(OFS_CMPL);

    rx_frame_t         frm;
    logic [15:0]       tfd_q;
    logic [DATA_W-1:0] sig_q;
    logic              sig_seen_q;
    logic [SLOT_N-1:0] cmpl_q;
    logic [DATA_W-1:0] cmpl_wide;
    logic              is_sdb;
    logic              cmpl_clr;

    always_comb begin
        frm.vld    = frm_valid;
        frm.kind   = frm_kind_e'(frm_kind);
        frm.status = frm_status;
        frm.error  = frm_error;
        frm.sig    = frm_sig;
        is_sdb     = frm_valid && (frm_kind_e'(frm_kind) == FRM_SDB);
        cmpl_clr   = reg_wr_en && (reg_addr == CMPL_ADDR);
    end

    sata_tf_shadow u_tf (
        .clk        (clk),
        .rst        (rst),
        .frm        (frm),
        .tfd_q      (tfd_q),
        .sig_q      (sig_q),
        .sig_seen_q (sig_seen_q),
        .irq_tferr  (irq_tferr),
        .irq_sdb    (irq_sdb)
    );

    sata_cmpl_accum #(.SLOT_N(SLOT_N)) u_cmpl (
        .clk      (clk),
        .rst      (rst),
        .set_vld  (is_sdb),
        .set_bits (frm_done),
        .clr_vld  (cmpl_clr),
        .clr_bits (reg_wdata[SLOT_N-1:0]),
        .acc_q    (cmpl_q)
    );

    generate
        if (SLOT_N < DATA_W) begin : g_pad
            assign cmpl_wide = {{(DATA_W-SLOT_N){1'b0}}, cmpl_q};
        end else begin : g_full
            assign cmpl_wide = cmpl_q;
        end
    endgenerate

    sata_reg_rdmux #(.ADDR_W(ADDR_W)) u_rd (
        .addr  (reg_addr),
        .tfd   (tfd_q),
        .sig   (sig_q),
        .link  (link_status),
        .cmpl  (cmpl_wide),
        .rdata (reg_rdata)
    );

endmodule

// File: rtl/sata_shadow_checker.sv
module sata_shadow_checker (
    input logic        clk,
    input logic        rst,
    input logic        frm_valid,
    input logic [1:0]  frm_kind,
    input logic        frm_err_bit,
    input logic [15:0] tfd_q,
    input logic [31:0] sig_q,
    input logic        sig_seen_q,
    input logic        irq_tferr,
    input logic        irq_sdb
);

    assert_tfd_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !frm_valid |=> $stable(tfd_q));

    assert_sdb_keeps_busy_R5: assert property (@(posedge clk) disable iff (rst)
        (frm_valid && frm_kind == 2'd2) |=>
            (tfd_q[7] == $past(tfd_q[7]) && tfd_q[3] == $past(tfd_q[3])));

    assert_tferr_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        (frm_valid && frm_kind[1] == 1'b0 && frm_err_bit) |=> irq_tferr);

    assert_sdb_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        (frm_valid && frm_kind == 2'd2) |=> irq_sdb);

    assert_no_spurious_irq_R7: assert property (@(posedge clk) disable iff (rst)
        !frm_valid |=> (!irq_sdb && !irq_tferr));

    assert_sig_locked_R10: assert property (@(posedge clk) disable iff (rst)
        sig_seen_q |=> $stable(sig_q));

endmodule

bind sata_port_shadow_regs sata_shadow_checker chk_i (
    .clk         (clk),
    .rst         (rst),
    .frm_valid   (frm_valid),
    .frm_kind    (frm_kind),
    .frm_err_bit (frm_status[0]),
    .tfd_q       (tfd_q),
    .sig_q       (sig_q),
    .sig_seen_q  (sig_seen_q),
    .irq_tferr   (irq_tferr),
    .irq_sdb     (irq_sdb)
);

// File: tb/sata_port_shadow_regs_tb.sv
module sata_port_shadow_regs_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr_en = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] link_status = 32'h0000_0123;
    logic        frm_valid = 1'b0;
    logic [1:0]  frm_kind = '0;
    logic [7:0]  frm_status = '0;
    logic [7:0]  frm_error = '0;
    logic [31:0] frm_done = '0;
    logic [31:0] frm_sig = '0;
    logic        irq_tferr;
    logic        irq_sdb;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    logic [15:0] m_tfd;
    logic [31:0] m_sig;
    logic        m_seen;
    logic [31:0] m_cmpl;

    always #2 clk = ~clk;

    sata_port_shadow_regs dut_i (
        .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .link_status(link_status),
        .frm_valid(frm_valid), .frm_kind(frm_kind), .frm_status(frm_status),
        .frm_error(frm_error), .frm_done(frm_done), .frm_sig(frm_sig),
        .irq_tferr(irq_tferr), .irq_sdb(irq_sdb)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_tfd = 16'h007F; m_sig = '1; m_seen = 1'b0; m_cmpl = '0;
    endtask

    task automatic check_regs(input string tag);
        logic [31:0] d;
        rd(4'd0, d); chk({tag, " tfd"}, d, {16'h0, m_tfd});
        rd(4'd1, d); chk({tag, " sig"}, d, m_sig);
        rd(4'd3, d); chk({tag, " cmpl"}, d, m_cmpl);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr_en = 1'b0;
        if (a == 4'd3) m_cmpl = m_cmpl & ~v;
    endtask

    // Drives one frame; optional same-cycle clear write to the completion register.
    task automatic send(input logic [1:0] k, input logic [7:0] st, input logic [7:0] er,
                        input logic [31:0] done, input logic [31:0] sg,
                        input bit do_clr, input logic [31:0] clr, input bit full_chk);
        logic [31:0] d;
        logic exp_tf, exp_sdb;
        @(negedge clk);
        frm_valid = 1'b1; frm_kind = k; frm_status = st; frm_error = er;
        frm_done = done; frm_sig = sg;
        reg_wr_en = do_clr; reg_wdata = clr;
        rd(do_clr ? 4'd3 : 4'd0, d);
        if (do_clr) chk("R2 same-cycle read old cmpl", d, m_cmpl);
        else        chk("R2 same-cycle read old tfd", d, {16'h0, m_tfd});
        exp_tf = 1'b0; exp_sdb = 1'b0;
        if (do_clr) m_cmpl = m_cmpl & ~clr;
        case (k)
            2'd0: begin
                m_tfd = {er, st}; exp_tf = st[0];
                if (!m_seen) begin m_sig = sg; m_seen = 1'b1; end
            end
            2'd1: begin m_tfd = {er, st}; exp_tf = st[0]; end
            2'd2: begin
                m_tfd = {er, (m_tfd[7:0] & 8'h88) | (st & 8'h77)};
                exp_sdb = 1'b1; m_cmpl = m_cmpl | done;
            end
            default: ;
        endcase
        @(negedge clk);
        frm_valid = 1'b0; reg_wr_en = 1'b0;
        #0.5;
        chk("R6 irq_tferr", {31'h0, irq_tferr}, {31'h0, exp_tf});
        chk("R7 irq_sdb", {31'h0, irq_sdb}, {31'h0, exp_sdb});
        rd(4'd0, d); chk("R4/R5 tfd after frame", d, {16'h0, m_tfd});
        if (full_chk) begin
            rd(4'd1, d); chk("R10 signature", d, m_sig);
            rd(4'd3, d); chk("R8/R9 cmpl", d, m_cmpl);
            @(negedge clk); #0.5;
            chk("R7 irq pulse ends", {30'h0, irq_tferr, irq_sdb}, 32'h0);
        end
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        do_reset();
        #0.5;
        check_regs("R1 reset");
        chk("R1 irqs at reset", {30'h0, irq_tferr, irq_sdb}, 32'h0);
        rd(4'd2, d); chk("R2 link mirror", d, 32'h0000_0123);
        rd(4'd7, d); chk("R2 unmapped offset", d, 32'h0);

        // R10: PIO before any register frame leaves signature at reset value
        send(2'd1, 8'h50, 8'h00, '0, 32'hAAAA_5555, 1'b0, '0, 1'b1);
        send(2'd0, 8'h41, 8'h04, '0, 32'h1234_5678, 1'b0, '0, 1'b1);
        send(2'd0, 8'h50, 8'h00, '0, 32'h0BAD_F00D, 1'b0, '0, 1'b1);
        send(2'd2, 8'h50, 8'h00, 32'h1, 32'hCAFE_0001, 1'b0, '0, 1'b1);

        // R3: writes to read-only offsets
        wr(4'd0, 32'hDEAD_BEEF);
        wr(4'd1, 32'hDEAD_BEEF);
        wr(4'd2, 32'hDEAD_BEEF);
        check_regs("R3 after ro writes");
        rd(4'd2, d); chk("R3 link unaffected", d, 32'h0000_0123);

        // R4/R6: full status sweeps for register and PIO frames
        for (int s = 0; s < 256; s++)
            send(2'd0, 8'(s), 8'(s) ^ 8'hA5, '0, 32'(s), 1'b0, '0, (s % 16) == 0);
        for (int s = 0; s < 256; s++)
            send(2'd1, 8'(s), ~8'(s), '0, '0, 1'b0, '0, (s % 16) == 0);

        // R5/R8: set-device-bits sweep over each busy/drq prior state
        for (int p = 0; p < 4; p++) begin
            for (int s = 0; s < 256; s++) begin
                send(2'd1, {p[1], 3'b000, p[0], 3'b010}, 8'h00, '0, '0, 1'b0, '0, 1'b0);
                send(2'd2, 8'(s), 8'(s + p), 32'(1) << (s % 32), '0, 1'b0, '0, (s % 32) == 7);
            end
        end
        rd(4'd3, d); chk("R8 all slots accumulated", d, 32'hFFFF_FFFF);

        // R9: write-one-to-clear
        wr(4'd3, 32'h0F0F_00FF);
        check_regs("R9 partial clear");
        // R9: clear and set in the same cycle, set wins
        send(2'd2, 8'h40, 8'h00, 32'h0000_0021, '0, 1'b1, 32'hFFFF_FFFF, 1'b1);
        rd(4'd3, d); chk("R9 set wins over clear", d, 32'h0000_0021);

        // R8: reserved kind has no effect
        send(2'd3, 8'hFF, 8'hFF, 32'hFFFF_0000, 32'h7777_7777, 1'b0, '0, 1'b1);

        // R1: port reset mid-run restores reset values
        do_reset();
        #0.5;
        check_regs("R1 second reset");
        send(2'd0, 8'h51, 8'h84, '0, 32'h0000_0101, 1'b0, '0, 1'b1);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule